// File: doc/BRIEF.md
# Condition Register Update Unit

This block owns a 32-bit condition register made of eight 4-bit flag groups. Each group holds a less-than flag, a greater-than flag, an equal flag and a copy of a sticky overflow bit. The integer pipeline writes into the register in two ways. A record update sorts an integer result into negative, positive or zero and writes group 0. A compare update compares two 32-bit operands, signed or unsigned, and writes a group picked by a 3-bit index.

The sticky overflow bit comes from an outside overflow register through `so_in`. The block only copies it into the group it writes. Updates take effect on the rising clock edge. The whole register is always visible on `cr_out`, and a second index `rd_sel` picks out one group on `rd_field` without a clock cycle of delay.

Top module: `cr_update_unit`

## Requirements
- R1: A synchronous active-high `rst` clears all 32 bits of `cr_out` to zero. The reset value is seen on the clock edge that samples `rst` high.
- R2: A record update writes group 0 with the code {LT,GT,EQ}. The code is 100 when bit 31 of the low result word is 1, 001 when the low word is zero, and 010 otherwise. Group n sits at `cr_out[31-4n:28-4n]`, in the order LT, GT, EQ, SO from the high bit down, so group 0 is `cr_out[31:28]`.
- R3: A record update reads only `res_value[31:0]`. Bits 63:32 have no effect on the flags.
- R4: A record update happens when `res_valid` is high, `res_dword` is low, and `res_record` or `res_imm` is high. With no qualifying record and no `cmp_valid`, `cr_out` holds its value.
- R5: A compare sets LT when `cmp_a` < `cmp_b`. The comparison is two's-complement when `cmp_signed` is 1 and unsigned when it is 0.
- R6: A compare sets GT when A > B and EQ when A = B, under the same signedness. Exactly one of LT, GT and EQ is set.
- R7: A compare writes group `cmp_field`, at the bit positions given in R2.
- R8: Bit SO of the written group equals `so_in` as sampled on the updating clock edge.
- R9: An update changes only its target group. The other seven groups keep their values.
- R10: When a compare and a qualifying record update arrive in the same cycle, only the compare is performed. Group 0 changes only if `cmp_field` is 0.
- R11: `rd_field` equals group `rd_sel` of the current `cr_out`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | Result strobe from the integer pipe |
| res_record | input | 1 | Result asks for a record update |
| res_imm | input | 1 | Immediate operation that always records |
| res_dword | input | 1 | Double-word operation, blocks record |
| res_value | input | 64 | Integer result |
| cmp_valid | input | 1 | Compare strobe |
| cmp_signed | input | 1 | 1 = signed compare, 0 = unsigned |
| cmp_field | input | 3 | Target group of the compare |
| cmp_a | input | 32 | Compare operand A |
| cmp_b | input | 32 | Compare operand B |
| so_in | input | 1 | Sticky summary-overflow bit |
| rd_sel | input | 3 | Group index for the read port |
| cr_out | output | 32 | Whole condition register |
| rd_field | output | 4 | Selected group {LT,GT,EQ,SO} |

## Verification
The hardest case to reach is a pair of operands whose result flips between a signed and an unsigned compare, landing in a group other than 0 while a record update collides in the same cycle. Random stimulus rarely lines all of that up. Directed steps therefore pair operands that straddle the sign boundary, such as all ones against one and the most negative value against the most positive, and apply them to every group index. A colliding record request carries a result whose flags differ from what is already in group 0, so a dropped write can be told apart from a performed one. Random record results put arbitrary data in the upper word while the low word is often forced to zero or to the sign boundary, which covers the flags in R2 and R3.

// File: rtl/cr_pkg.sv
package cr_pkg;

  localparam int GRP_W = 4;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cr_grp_t;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
  } cr_flags_t;

  function automatic cr_grp_t make_grp(input cr_flags_t f, input logic so);
    cr_grp_t g;
    g.lt = f.lt;
    g.gt = f.gt;
    g.eq = f.eq;
    g.so = so;
    return g;
  endfunction

endpackage

// File: rtl/cr_record_eval.sv
module cr_record_eval
  import cr_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  output cr_flags_t         flags
);

  logic is_neg;
  logic is_zero;

  assign is_neg  = word[WORD_W-1];
  assign is_zero = (word == '0);

  always_comb begin
    flags.lt = is_neg;
    flags.eq = is_zero;
    flags.gt = ~is_neg & ~is_zero;
  end

endmodule

// File: rtl/cr_compare_eval.sv
module cr_compare_eval
  import cr_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              signed_mode,
  output cr_flags_t         flags
);

  logic less_s;
  logic less_u;
  logic same;
  logic less;

  assign less_s = $signed(op_a) < $signed(op_b);
  assign less_u = op_a < op_b;
  assign same   = (op_a == op_b);
  assign less   = signed_mode ? less_s : less_u;

  always_comb begin
    flags.lt = less;
    flags.eq = same;
    flags.gt = ~less & ~same;
  end

endmodule

// File: rtl/cr_group_bank.sv
module cr_group_bank
  import cr_pkg::*;
#(
  parameter int NUM_GRP = 8,
  parameter int SEL_W   = $clog2(NUM_GRP),
  parameter int CR_W    = NUM_GRP * GRP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  cr_grp_t          wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [CR_W-1:0]  cr_q,
  output cr_grp_t          rd_grp
);

  cr_grp_t grp_q [NUM_GRP];

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic hit;
    assign hit = wr_en && (wr_sel == SEL_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        grp_q[g] <= '0;
      end else if (hit) begin
        grp_q[g] <= wr_data;
      end
    end

    assign cr_q[CR_W-1-GRP_W*g -: GRP_W] = grp_q[g];
  end

  always_comb begin
    rd_grp = '0;
    for (int i = 0; i < NUM_GRP; i++) begin
      if (rd_sel == SEL_W'(i)) begin
        rd_grp = grp_q[i];
      end
    end
  end

endmodule

// File: rtl/cr_update_unit.sv
module cr_update_unit
  import cr_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int RES_W   = 64,
  parameter int NUM_GRP = 8,
  localparam int SEL_W  = $clog2(NUM_GRP),
  localparam int CR_W   = NUM_GRP * GRP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic              res_record,
  input  logic              res_imm,
  input  logic              res_dword,
  input  logic [RES_W-1:0]  res_value,
  input  logic              cmp_valid,
  input  logic              cmp_signed,
  input  logic [SEL_W-1:0]  cmp_field,
  input  logic [WORD_W-1:0] cmp_a,
  input  logic [WORD_W-1:0] cmp_b,
  input  logic              so_in,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [CR_W-1:0]   cr_out,
  output logic [GRP_W-1:0]  rd_field
);

  cr_flags_t rec_flags;
  cr_flags_t cmp_flags;
  cr_grp_t   wr_data;
  cr_grp_t   rd_grp;
  logic      rec_req;
  logic      wr_en;
  logic [SEL_W-1:0] wr_sel;

  cr_record_eval #(.WORD_W(WORD_W)) i_rec (
    .word  (res_value[WORD_W-1:0]),
    .flags (rec_flags)
  );

  cr_compare_eval #(.WORD_W(WORD_W)) i_cmp (
    .op_a        (cmp_a),
    .op_b        (cmp_b),
    .signed_mode (cmp_signed),
    .flags       (cmp_flags)
  );

  assign rec_req = res_valid & ~res_dword & (res_record | res_imm);
  assign wr_en   = cmp_valid | rec_req;
  assign wr_sel  = cmp_valid ? cmp_field : '0;
  assign wr_data = make_grp(cmp_valid ? cmp_flags : rec_flags, so_in);

  cr_group_bank #(.NUM_GRP(NUM_GRP)) i_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .cr_q    (cr_out),
    .rd_grp  (rd_grp)
  );

  assign rd_field = rd_grp;

endmodule

// File: rtl/cr_update_checker.sv
module cr_update_checker #(
  parameter int WORD_W  = 32,
  parameter int NUM_GRP = 8,
  parameter int SEL_W   = $clog2(NUM_GRP),
  parameter int CR_W    = NUM_GRP * 4
) (
  input logic              clk,
  input logic              rst,
  input logic              res_valid,
  input logic              res_record,
  input logic              res_imm,
  input logic              res_dword,
  input logic [WORD_W-1:0] res_lo,
  input logic              cmp_valid,
  input logic              cmp_signed,
  input logic [SEL_W-1:0]  cmp_field,
  input logic [WORD_W-1:0] cmp_a,
  input logic [WORD_W-1:0] cmp_b,
  input logic              so_in,
  input logic [CR_W-1:0]   cr_out
);

  function automatic logic [3:0] grp_of(input logic [CR_W-1:0] v, input logic [SEL_W-1:0] s);
    logic [3:0] r;
    r = '0;
    for (int i = 0; i < NUM_GRP; i++) begin
      if (s == SEL_W'(i)) r = v[CR_W-1-4*i -: 4];
    end
    return r;
  endfunction

  function automatic logic [CR_W-1:0] mask_of(input logic [SEL_W-1:0] s);
    logic [CR_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_GRP; i++) begin
      if (s == SEL_W'(i)) m[CR_W-1-4*i -: 4] = 4'hF;
    end
    return m;
  endfunction

  logic             rec_fire;
  logic [SEL_W-1:0] tgt_q;
  logic [3:0]       tgt_grp;
  logic [CR_W-1:0]  tgt_mask;

  assign rec_fire = res_valid & ~res_dword & (res_record | res_imm);

  always_ff @(posedge clk) begin
    tgt_q <= cmp_valid ? cmp_field : '0;
  end

  assign tgt_grp  = grp_of(cr_out, tgt_q);
  assign tgt_mask = mask_of(tgt_q);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> cr_out == '0);

  assert_rec_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rec_fire && !cmp_valid && res_lo == '0) |=> cr_out[CR_W-1 -: 3] == 3'b001);

  assert_rec_neg_R2: assert property (@(posedge clk) disable iff (rst)
    (rec_fire && !cmp_valid && res_lo[WORD_W-1]) |=> cr_out[CR_W-1 -: 3] == 3'b100);

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!cmp_valid && !rec_fire) |=> $stable(cr_out));

  assert_cmp_signed_R5: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_signed && ($signed(cmp_a) < $signed(cmp_b))) |=> tgt_grp[3]);

  assert_cmp_unsigned_R5: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && !cmp_signed && (cmp_a < cmp_b)) |=> tgt_grp[3]);

  assert_cmp_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    cmp_valid |=> $countones(tgt_grp[3:1]) == 1);

  assert_cmp_equal_R6: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && cmp_a == cmp_b) |=> tgt_grp[1]);

  assert_so_copy_R8: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid || rec_fire) |=> tgt_grp[0] == $past(so_in));

  assert_others_kept_R9: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid || rec_fire) |=> (cr_out & ~tgt_mask) == ($past(cr_out) & ~tgt_mask));

  assert_cmp_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (cmp_valid && rec_fire && cmp_field != '0) |=> cr_out[CR_W-1 -: 4] == $past(cr_out[CR_W-1 -: 4]));

endmodule

bind cr_update_unit cr_update_checker #(
  .WORD_W  (WORD_W),
  .NUM_GRP (NUM_GRP)
) i_cr_update_checker (
  .clk        (clk),
  .rst        (rst),
  .res_valid  (res_valid),
  .res_record (res_record),
  .res_imm    (res_imm),
  .res_dword  (res_dword),
  .res_lo     (res_value[WORD_W-1:0]),
  .cmp_valid  (cmp_valid),
  .cmp_signed (cmp_signed),
  .cmp_field  (cmp_field),
  .cmp_a      (cmp_a),
  .cmp_b      (cmp_b),
  .so_in      (so_in),
  .cr_out     (cr_out)
);

// File: tb/test_cr_update_unit.sv
module test_cr_update_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        res_valid, res_record, res_imm, res_dword;
  logic [63:0] res_value;
  logic        cmp_valid, cmp_signed;
  logic [2:0]  cmp_field;
  logic [31:0] cmp_a, cmp_b;
  logic        so_in;
  logic [2:0]  rd_sel;
  logic [31:0] cr_out;
  logic [3:0]  rd_field;

  int total = 0;
  int bad   = 0;
  logic [31:0] model = '0;

  always #10 clk = ~clk;

  cr_update_unit i_cr_update_unit (
    .clk(clk), .rst(rst),
    .res_valid(res_valid), .res_record(res_record), .res_imm(res_imm),
    .res_dword(res_dword), .res_value(res_value),
    .cmp_valid(cmp_valid), .cmp_signed(cmp_signed), .cmp_field(cmp_field),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .so_in(so_in),
    .rd_sel(rd_sel), .cr_out(cr_out), .rd_field(rd_field)
  );

  function automatic logic [3:0] rec_ref(input logic [63:0] v, input logic so);
    logic [31:0] lo;
    lo = v[31:0];
    if (lo[31])          return {3'b100, so};
    else if (lo == 0)    return {3'b001, so};
    else                 return {3'b010, so};
  endfunction

  function automatic logic [3:0] cmp_ref(input logic [31:0] a, input logic [31:0] b,
                                         input logic sgn, input logic so);
    logic lt, gt;
    if (sgn) begin
      lt = $signed(a) < $signed(b);
      gt = $signed(a) > $signed(b);
    end else begin
      lt = a < b;
      gt = a > b;
    end
    return {lt, gt, (a == b), so};
  endfunction

  function automatic logic [31:0] put_grp(input logic [31:0] cr, input int n, input logic [3:0] f);
    logic [31:0] r;
    r = cr;
    r[31-4*n -: 4] = f;
    return r;
  endfunction

  function automatic logic [3:0] get_grp(input logic [31:0] cr, input int n);
    return cr[31-4*n -: 4];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    res_valid = 0; res_record = 0; res_imm = 0; res_dword = 0; res_value = '0;
    cmp_valid = 0; cmp_signed = 0; cmp_field = '0; cmp_a = '0; cmp_b = '0;
  endtask

  // Drives one cycle of requests at a falling edge, updates the model at the rising edge,
  // then compares the register at the next falling edge.
  task automatic op(input logic rv, input logic rr, input logic ri, input logic rd,
                    input logic [63:0] val, input logic cv, input logic cs,
                    input logic [2:0] cf, input logic [31:0] a, input logic [31:0] b,
                    input logic so, input string req);
    res_valid = rv; res_record = rr; res_imm = ri; res_dword = rd; res_value = val;
    cmp_valid = cv; cmp_signed = cs; cmp_field = cf; cmp_a = a; cmp_b = b; so_in = so;
    @(posedge clk);
    if (cv)                       model = put_grp(model, int'(cf), cmp_ref(a, b, cs, so));
    else if (rv && !rd && (rr || ri)) model = put_grp(model, 0, rec_ref(val, so));
    @(negedge clk);
    check(req, cr_out, model);
    idle();
  endtask

  task automatic sweep_read(input string req);
    for (int i = 0; i < 8; i++) begin
      rd_sel = 3'(i);
      #1;
      check(req, {28'd0, rd_field}, {28'd0, get_grp(model, i)});
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    idle();
    so_in = 0;
    rd_sel = '0;
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 reset", cr_out, 32'h0);
    sweep_read("R11 read after reset");

    // Record mode: flag codes in group 0
    op(1,1,0,0, 64'h0,                 0,0,0,0,0, 0, "R2 record zero");
    op(1,1,0,0, 64'h0000_0000_8000_0000, 0,0,0,0,0, 1, "R2 record negative");
    op(1,1,0,0, 64'h0000_0000_7FFF_FFFF, 0,0,0,0,0, 0, "R2 record positive");
    op(1,1,0,0, 64'h0000_0000_0000_0001, 0,0,0,0,0, 1, "R2 record one");
    // Upper word must not matter
    op(1,1,0,0, 64'hFFFF_FFFF_0000_0000, 0,0,0,0,0, 0, "R3 upper set low zero");
    op(1,1,0,0, 64'h8000_0000_0000_0005, 0,0,0,0,0, 0, "R3 upper negative low positive");
    // Qualification of record updates
    op(1,0,1,0, 64'h0000_0000_FFFF_FFFF, 0,0,0,0,0, 1, "R4 immediate records");
    op(1,1,0,1, 64'h0,                   0,0,0,0,0, 0, "R4 dword ignored");
    op(1,0,0,0, 64'h0,                   0,0,0,0,0, 0, "R4 no record bit ignored");
    op(0,1,1,0, 64'h0,                   0,0,0,0,0, 0, "R4 no strobe ignored");

    // Compare: sign boundary on every group
    for (int n = 0; n < 8; n++) begin
      op(0,0,0,0, 0, 1,1,3'(n), 32'hFFFF_FFFF, 32'h1, n[0], "R5 R7 signed minus one");
      op(0,0,0,0, 0, 1,0,3'(n), 32'hFFFF_FFFF, 32'h1, n[1], "R5 R7 unsigned all ones");
    end
    op(0,0,0,0, 0, 1,1,3'd5, 32'h8000_0000, 32'h7FFF_FFFF, 0, "R5 signed extremes");
    op(0,0,0,0, 0, 1,0,3'd6, 32'h8000_0000, 32'h7FFF_FFFF, 1, "R6 unsigned extremes");
    op(0,0,0,0, 0, 1,1,3'd3, 32'h1234_5678, 32'h1234_5678, 0, "R6 equal signed");
    op(0,0,0,0, 0, 1,0,3'd7, 32'h0,         32'h0,         1, "R6 R8 equal zero");
    sweep_read("R11 read sweep");

    // Collision: record would write 100 to group 0 but compare wins
    op(0,0,0,0, 0, 1,0,3'd0, 32'h5, 32'h5, 0, "R9 set group 0");
    op(1,1,0,0, 64'h8000_0000, 1,0,3'd4, 32'h1, 32'h2, 1, "R10 compare wins elsewhere");
    op(1,1,0,0, 64'h8000_0000, 1,1,3'd0, 32'h9, 32'h2, 0, "R10 compare wins group 0");

    // Random mix
    for (int k = 0; k < 600; k++) begin
      logic [63:0] v;
      logic [31:0] a, b;
      v = {$urandom(), $urandom()};
      case ($urandom() % 4)
        0: v[31:0] = '0;
        1: v[31:0] = 32'h8000_0000;
        default: ;
      endcase
      a = $urandom();
      b = ($urandom() % 3 == 0) ? a : $urandom();
      op(($urandom() % 2) == 0, ($urandom() % 2) == 0, ($urandom() % 4) == 0,
         ($urandom() % 4) == 0, v, ($urandom() % 3) == 0, ($urandom() % 2) == 0,
         3'($urandom()), a, b, ($urandom() % 2) == 0, "R9 random mix");
      if (k % 100 == 0) sweep_read("R11 random read");
    end

    // Reset in the middle of a run
    rst = 1;
    @(negedge clk);
    rst = 0;
    model = '0;
    check("R1 mid-run reset", cr_out, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule